// File: doc/BRIEF.md
# Receive Interrupt Coalescer with Tag Handshake

This block decides when a single receive channel raises an interrupt towards the host. It also builds the 32-bit status word that travels with each interrupt. Every received message arrives as a one-cycle strobe and is added to a pending batch. The batch is reported when either of two limits is reached. The first is a message-count limit. The second is a time limit, counted in coarse time units from the first message of the batch.

Each interrupt carries a 4-bit rolling tag. After an interrupt, the channel stays silent until the host writes back the tag that follows it. Messages and transmit link events that arrive in the meantime keep collecting for the next report.

A small register port controls the block. It has a set address and a clear address for the three control bits: uncached, receive-path reset and interrupt enable. It also has a limit register and an acknowledge register. While the reset bit is set, the receive path is held idle and all pending state is discarded.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After reset, `irq_o` is 0 and `status_o` is 0. `ctl_o` is 3'b010, meaning the receive-path reset bit is set and interrupt enable and uncached are clear. The count limit is 16 and the time limit is 10 units.
- R2: A write with `reg_sel_i`=0 (set) ORs `reg_wdata_i[18:16]` into the control bits. A write with `reg_sel_i`=1 (clear) removes those bits. Bit 16 is uncached (`ctl_o[0]`), bit 17 is receive-path reset (`ctl_o[1]`) and bit 18 is interrupt enable (`ctl_o[2]`). Each change shows on `ctl_o` one cycle after the write.
- R3: While the reset bit is set, the following are all ignored: message strobes, link strobes and acknowledge writes. No interrupt is raised. Setting the bit discards the pending batch and drops the armed state, but keeps the tag.
- R4: A write with `reg_sel_i`=2 loads the count limit from `reg_wdata_i[7:0]` and the time limit from `reg_wdata_i[15:8]`. When armed and enabled, the block fires once the pending count is non-zero and at least the count limit.
- R5: When armed and enabled, the block also fires if anything is pending and the batch timer has reached the time limit. The timer counts one unit per TICKS_PER_UNIT cycles, starting from the first message or link event of the batch.
- R6: `irq_o` is a one-cycle pulse. It updates in the same edge as `status_o`, which then holds until the next interrupt. The status fields are:
  - bits [3:0]: the tag
  - bits [10:4]: the message count of the batch
  - bit 16: a link event was seen
  - all other bits: 0
- R7: Each interrupt's tag is the previous tag plus one, modulo 16, so the first tag is 1 and 15 is followed by 0. The channel arms only on a write with `reg_sel_i`=3 whose `reg_wdata_i[3:0]` equals the last tag plus one. Any other acknowledge value has no effect.
- R8: After an interrupt, no further interrupt fires until a matching acknowledge. Messages keep accumulating in the meantime. If a limit is already met when the acknowledge arrives, the interrupt fires on the next cycle.
- R9: The pending message count saturates at 127.
- R10: With interrupt enable clear, no interrupt fires, but messages still accumulate. Setting enable fires at once if a limit is met.
- R11: A link strobe alone makes the batch pending and sets status bit 16 in the next report.
- R12: A batch consumed by an interrupt restarts empty. A message that arrives in the firing cycle opens the next batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 set, 1 clear, 2 limits, 3 acknowledge |
| reg_wdata_i | input | 32 | Register write data |
| msg_rx_i | input | 1 | One-cycle strobe per received message |
| link_evt_i | input | 1 | One-cycle strobe for a transmit link event |
| irq_o | output | 1 | Interrupt pulse |
| status_o | output | 32 | Status word of the last interrupt |
| ctl_o | output | 3 | Control bits {enable, reset, uncached} |

## Verification
The main function is exercised with several stimulus patterns, each aimed at a different behaviour:

- **Bursts that reach the count limit** show that the count path fires, both with the default limit and with a programmed one.
- **Short bursts that stay below the limit** show that the time path fires, and that its latency is measured from the first message.
- **Bursts arriving while unacknowledged**, then wrong and right acknowledge values, separate the tag gate from the coalescing logic.
- **A lone link strobe, a burst of 130 messages with enable off, and a burst cut short by the reset bit** cover, in turn, link-only reports, saturation at 127 and discarding of a pending batch.
- **A run of single-message interrupts past tag 15** checks the tag wrap.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic [1:0] {
    SEL_CTL_SET = 2'd0,
    SEL_CTL_CLR = 2'd1,
    SEL_LIMITS  = 2'd2,
    SEL_ACK     = 2'd3
  } reg_sel_e;

  localparam int unsigned TAG_W        = 4;
  localparam int unsigned CNT_W        = 7;
  localparam int unsigned LIM_W        = 8;
  localparam int unsigned STAT_W       = 32;
  localparam int unsigned STAT_CNT_LSB = 4;
  localparam int unsigned STAT_LNK_BIT = 16;
  localparam int unsigned CTL_LSB      = 16;
  localparam int unsigned CTL_N        = 3;

  typedef struct packed {
    logic ien;
    logic dma_rst;
    logic uncached;
  } ctl_t;
endpackage

// File: rtl/rxc_regs.sv
module rxc_regs
  import rxc_pkg::*;
#(
  parameter int unsigned DEF_CNT_LIM  = 16,
  parameter int unsigned DEF_TIME_LIM = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [CTL_N-1:0] ctl_bits_i,
  input  logic [LIM_W-1:0] cnt_lim_i,
  input  logic [LIM_W-1:0] time_lim_i,
  output ctl_t             ctl_o,
  output logic [LIM_W-1:0] cnt_lim_o,
  output logic [LIM_W-1:0] time_lim_o
);
  ctl_t ctl_q;
  logic [LIM_W-1:0] cnt_lim_q, time_lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= '{ien: 1'b0, dma_rst: 1'b1, uncached: 1'b0};
      cnt_lim_q  <= LIM_W'(DEF_CNT_LIM);
      time_lim_q <= LIM_W'(DEF_TIME_LIM);
    end else if (we_i) begin
      unique case (reg_sel_e'(sel_i))
        SEL_CTL_SET: ctl_q <= ctl_q | ctl_t'(ctl_bits_i);
        SEL_CTL_CLR: ctl_q <= ctl_q & ~ctl_t'(ctl_bits_i);
        SEL_LIMITS: begin
          cnt_lim_q  <= cnt_lim_i;
          time_lim_q <= time_lim_i;
        end
        default: ;
      endcase
    end
  end

  assign ctl_o      = ctl_q;
  assign cnt_lim_o  = cnt_lim_q;
  assign time_lim_o = time_lim_q;
endmodule

// File: rtl/rxc_tag_gate.sv
module rxc_tag_gate
  import rxc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fire_i,
  input  logic             ack_we_i,
  input  logic [TAG_W-1:0] ack_tag_i,
  output logic             armed_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [TAG_W-1:0] next_tag_o
);
  logic armed_q;
  logic [TAG_W-1:0] tag_q, next_tag;
  logic ack_ok;

  assign next_tag = tag_q + TAG_W'(1);
  // an ack counts only when disarmed and carrying the tag after the last one
  assign ack_ok   = ack_we_i && run_i && !armed_q && (ack_tag_i == next_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      if (!run_i || fire_i) armed_q <= 1'b0;
      else if (ack_ok)      armed_q <= 1'b1;
      if (fire_i) tag_q <= next_tag;
    end
  end

  assign armed_o    = armed_q;
  assign tag_o      = tag_q;
  assign next_tag_o = next_tag;
endmodule

// File: rtl/rxc_batch.sv
module rxc_batch
  import rxc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fire_i,
  input  logic             msg_i,
  input  logic             link_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             lnk_o,
  output logic             pending_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_base;
  logic lnk_q;

  // a message arriving in the firing cycle opens the next batch
  assign cnt_base = fire_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lnk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      lnk_q <= 1'b0;
    end else begin
      cnt_q <= (msg_i && cnt_base != CNT_MAX) ? cnt_base + CNT_W'(1) : cnt_base;
      lnk_q <= (lnk_q && !fire_i) || link_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign lnk_o     = lnk_q;
  assign pending_o = (cnt_q != '0) || lnk_q;
endmodule

// File: rtl/rxc_timer.sv
module rxc_timer
  import rxc_pkg::*;
#(
  parameter int unsigned TICKS_PER_UNIT = 20000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [LIM_W-1:0] units_o
);
  localparam int unsigned PRE_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_UNIT - 1);
  localparam logic [LIM_W-1:0] UNIT_MAX = '1;

  logic [PRE_W-1:0] pre_q;
  logic [LIM_W-1:0] units_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (clear_i) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
      if (units_q != UNIT_MAX) units_q <= units_q + LIM_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  assign units_o = units_q;
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
  import rxc_pkg::*;
#(
  parameter int unsigned TICKS_PER_UNIT = 20000,
  parameter int unsigned DEF_CNT_LIM    = 16,
  parameter int unsigned DEF_TIME_LIM   = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  input  logic        msg_rx_i,
  input  logic        link_evt_i,
  output logic        irq_o,
  output logic [31:0] status_o,
  output logic [2:0]  ctl_o
);
  ctl_t ctl;
  logic [LIM_W-1:0] cnt_lim, time_lim, units;
  logic [CNT_W-1:0] cnt;
  logic [TAG_W-1:0] tag, next_tag;
  logic lnk, pending, armed, run, fire, ack_we, cnt_hit, time_hit;
  logic irq_q;
  logic [STAT_W-1:0] status_q, status_d;
  logic unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[31:CTL_LSB+CTL_N], tag};

  rxc_regs #(
    .DEF_CNT_LIM (DEF_CNT_LIM),
    .DEF_TIME_LIM(DEF_TIME_LIM)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .ctl_bits_i(reg_wdata_i[CTL_LSB +: CTL_N]),
    .cnt_lim_i (reg_wdata_i[LIM_W-1:0]),
    .time_lim_i(reg_wdata_i[2*LIM_W-1:LIM_W]),
    .ctl_o     (ctl),
    .cnt_lim_o (cnt_lim),
    .time_lim_o(time_lim)
  );

  assign run    = !ctl.dma_rst;
  assign ack_we = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_ACK);

  rxc_tag_gate u_tag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .fire_i    (fire),
    .ack_we_i  (ack_we),
    .ack_tag_i (reg_wdata_i[TAG_W-1:0]),
    .armed_o   (armed),
    .tag_o     (tag),
    .next_tag_o(next_tag)
  );

  rxc_batch u_batch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .fire_i   (fire),
    .msg_i    (msg_rx_i),
    .link_i   (link_evt_i),
    .cnt_o    (cnt),
    .lnk_o    (lnk),
    .pending_o(pending)
  );

  rxc_timer #(
    .TICKS_PER_UNIT(TICKS_PER_UNIT)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!run || fire || !pending),
    .units_o(units)
  );

  assign cnt_hit  = (cnt != '0) && (LIM_W'(cnt) >= cnt_lim);
  assign time_hit = pending && (units >= time_lim);
  assign fire     = run && ctl.ien && armed && (cnt_hit || time_hit);

  always_comb begin
    status_d = '0;
    status_d[TAG_W-1:0]               = next_tag;
    status_d[STAT_CNT_LSB +: CNT_W]   = cnt;
    status_d[STAT_LNK_BIT]            = lnk;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b0;
      status_q <= '0;
    end else begin
      irq_q <= fire;
      if (fire) status_q <= status_d;
    end
  end

  assign irq_o    = irq_q;
  assign status_o = status_q;
  assign ctl_o    = ctl;
endmodule

// File: rtl/rx_irq_coalescer_chk.sv
module rx_irq_coalescer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        irq_o,
  input logic [31:0] status_o,
  input logic [2:0]  ctl_o
);
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o) else $error("irq longer than one cycle"); // R6

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> $stable(status_o)) else $error("status moved without irq"); // R6

  AST_TAG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o[3:0] == 4'($past(status_o[3:0]) + 4'd1)) else $error("tag step"); // R7

  AST_QUIET_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[1] && $past(ctl_o[1])) |-> !irq_o) else $error("irq while held"); // R3

  AST_QUIET_NO_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctl_o[2]) |-> !irq_o) else $error("irq without enable"); // R10

  AST_REPORT_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o[10:4] != 7'd0 || status_o[16])) else $error("empty report"); // R5
endmodule

bind rx_irq_coalescer rx_irq_coalescer_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .status_o(status_o),
  .ctl_o   (ctl_o)
);

// File: tb/rx_irq_coalescer_tb_top.sv
`timescale 1ns/1ps
module rx_irq_coalescer_tb_top;
  localparam int TPU = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic msg = 1'b0;
  logic lnk = 1'b0;
  logic irq;
  logic [31:0] status;
  logic [2:0] ctl;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  rx_irq_coalescer #(.TICKS_PER_UNIT(TPU)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .msg_rx_i(msg), .link_evt_i(lnk),
    .irq_o(irq), .status_o(status), .ctl_o(ctl)
  );

  // behavioural reference model
  int m_cnt, m_pre, m_unit, m_tag, m_cl, m_tl;
  bit m_lnk, m_armed, m_unc, m_rst, m_ien, m_irq;
  bit m_run, m_pend, m_fire, m_ack;
  logic [31:0] m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_unit = 0; m_tag = 0; m_cl = 16; m_tl = 10;
      m_lnk = 0; m_armed = 0; m_unc = 0; m_rst = 1; m_ien = 0; m_irq = 0;
      m_stat = 0;
    end else begin
      m_run  = !m_rst;
      m_pend = (m_cnt > 0) || m_lnk;
      m_fire = m_run && m_ien && m_armed &&
               ((m_cnt > 0 && m_cnt >= m_cl) || (m_pend && m_unit >= m_tl));
      m_ack  = we && sel == 2'd3 && m_run && !m_armed && (wdata[3:0] == 4'((m_tag + 1) % 16));
      m_irq  = m_fire;
      if (m_fire) begin
        m_tag  = (m_tag + 1) % 16;
        m_stat = 32'(m_tag) | (32'(m_cnt) << 4) | (32'(m_lnk) << 16);
      end
      if (!m_run || m_fire) m_armed = 0;
      else if (m_ack) m_armed = 1;
      if (!m_run || m_fire || !m_pend) begin
        m_pre = 0; m_unit = 0;
      end else if (m_pre == TPU - 1) begin
        m_pre = 0;
        if (m_unit < 255) m_unit++;
      end else m_pre++;
      if (!m_run) begin
        m_cnt = 0; m_lnk = 0;
      end else begin
        if (m_fire) begin m_cnt = 0; m_lnk = 0; end
        if (msg && m_cnt < 127) m_cnt++;
        if (lnk) m_lnk = 1;
      end
      if (we && sel == 2'd0) begin
        if (wdata[16]) m_unc = 1; if (wdata[17]) m_rst = 1; if (wdata[18]) m_ien = 1;
      end else if (we && sel == 2'd1) begin
        if (wdata[16]) m_unc = 0; if (wdata[17]) m_rst = 0; if (wdata[18]) m_ien = 0;
      end else if (we && sel == 2'd2) begin
        m_cl = int'(wdata[7:0]); m_tl = int'(wdata[15:8]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (irq !== m_irq || status !== m_stat || ctl !== {m_ien, m_rst, m_unc}) begin
        n_bad++;
        $display("FAIL %s cycle %0d: irq/status/ctl actual %b/%h/%b expected %b/%h/%b",
                 cur_req, cycles, irq, status, ctl, m_irq, m_stat, {m_ien, m_rst, m_unc});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = 32'd0;
  endtask

  task automatic msgs(input int n);
    for (int i = 0; i < n; i++) begin
      msg = 1'b1;
      @(negedge clk);
    end
    msg = 1'b0;
  endtask

  task automatic wait_irq(input string req, input int max, input logic [31:0] exp);
    int k = 0;
    while (!irq && k < max) begin
      @(negedge clk);
      k++;
    end
    check(req, {31'd0, irq}, 32'd1);
    check(req, status, exp);
    @(negedge clk);
  endtask

  task automatic quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) seen++;
    end
    check(req, 32'(seen), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", {29'd0, ctl}, 32'd2);
    check("R1", status, 32'd0);
    check("R1", {31'd0, irq}, 32'd0);

    cur_req = "R2";
    wr(2'd0, 32'h0001_0000);
    check("R2", {29'd0, ctl}, 32'd3);
    wr(2'd1, 32'h0001_0000);
    check("R2", {29'd0, ctl}, 32'd2);
    wr(2'd0, 32'h0004_0000);
    check("R2", {29'd0, ctl}, 32'd6);

    cur_req = "R3";
    msgs(20);
    wr(2'd3, 32'd1);
    wr(2'd1, 32'h0002_0000);
    check("R3", {29'd0, ctl}, 32'd4);
    wr(2'd3, 32'd1);
    quiet("R3", 80);

    cur_req = "R4";
    msgs(16);
    wait_irq("R4 R6 R12", 10, 32'h0000_0101);

    cur_req = "R8";
    msgs(5);
    quiet("R8", 80);
    wr(2'd3, 32'd3);
    quiet("R7", 10);
    wr(2'd3, 32'd2);
    wait_irq("R8", 5, 32'h0000_0052);

    cur_req = "R5";
    wr(2'd3, 32'd3);
    msgs(3);
    quiet("R5", 40);
    wait_irq("R5", 20, 32'h0000_0033);

    cur_req = "R4";
    wr(2'd2, 32'h0000_0204);
    wr(2'd3, 32'd4);
    msgs(4);
    wait_irq("R4", 5, 32'h0000_0044);

    cur_req = "R11";
    wr(2'd3, 32'd5);
    lnk = 1'b1; @(negedge clk); lnk = 1'b0;
    wait_irq("R11", 20, 32'h0001_0005);

    cur_req = "R10";
    wr(2'd2, 32'h0000_28C8);
    wr(2'd1, 32'h0004_0000);
    wr(2'd3, 32'd6);
    msgs(130);
    quiet("R10", 300);
    cur_req = "R9";
    wr(2'd0, 32'h0004_0000);
    wait_irq("R9 R10", 5, 32'h0000_07F6);

    cur_req = "R7";
    wr(2'd2, 32'h0000_0201);
    for (int t = 7; t < 18; t++) begin
      wr(2'd3, 32'(t % 16));
      msgs(1);
      wait_irq("R7", 5, 32'h10 | 32'(t % 16));
    end

    cur_req = "R3";
    wr(2'd2, 32'h0000_3214);
    wr(2'd3, 32'd2);
    msgs(2);
    wr(2'd0, 32'h0002_0000);
    wr(2'd1, 32'h0002_0000);
    wr(2'd3, 32'd2);
    quiet("R3", 400);
    msgs(1);
    wait_irq("R3 R5", 300, 32'h0000_0012);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule